// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address stream for a four-beat memory burst. A load strobe captures an external address. The two lowest bits become the starting offset of the burst, and the remaining upper bits are held for the rest of the burst. Each later cycle with the active-low advance input asserted moves the burst one beat forward. With advance released, the current address is held, so the burst is suspended for as long as needed.

A mode input picks how the low two bits move. In linear order they count upward from the starting offset and wrap modulo four. In interleaved order the k-th beat is the starting offset XOR k. In both orders the fifth address of an uninterrupted burst is the starting address again. A load may arrive on any cycle and always restarts the sequence, even in the middle of a burst.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears the address, so addr_o reads all zeros from the cycle after that edge.
- R2: When load_i is high at a rising edge, addr_o equals the addr_i value sampled at that edge from the following cycle onward, until the next advance or load.
- R3: With mode_i low (linear order), each edge with adv_n_i low and load_i low raises the two low bits of addr_o by one, modulo four (for example, start 01 gives 01, 10, 11, 00).
- R4: With mode_i high (interleaved order), after k advances since the last load the two low bits of addr_o equal the start offset XOR k (for example, start 10 gives 10, 11, 00, 01).
- R5: In either order, the fourth advance after a load returns the two low bits of addr_o to the start offset.
- R6: An edge with adv_n_i high and load_i low leaves addr_o unchanged while mode_i is unchanged.
- R7: The upper bits of addr_o (all bits above bit 1) change only on a load edge, where they take the upper bits of addr_i.
- R8: When load_i is high and adv_n_i is low at the same edge, the load takes effect and no advance occurs: addr_o equals addr_i in the next cycle.
- R9: The order is applied combinationally from the beat count and the start offset. Changing mode_i in the middle of a burst makes addr_o show, in the same cycle, the beat reached so far under the new order, and does not restart the burst.
- R10: Advancing without any load after reset steps from start offset 00 in the selected order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Capture addr_i and restart the burst, active high |
| adv_n_i | input | 1 | Advance the burst one beat, active low; high suspends |
| mode_i | input | 1 | Order select: 0 = linear, 1 = interleaved |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current burst address |

## Verification
Load and advance can both be requested at the same edge. Mode can also change while a burst is in progress. The bench creates the first case by asserting load_i with adv_n_i held low in the middle of a running burst. It then expects the newly loaded address one cycle later, not the next beat of the old burst. For the second case, the bench flips mode_i between beats. A behavioural model, which recomputes the address from its own beat count every cycle, judges that addr_o switches order without losing its place in the burst.

// File: rtl/burst_pkg.sv
// Package: shared types and widths for the burst address sequencer.
// Assumes a fixed four-beat burst, so the beat lane is two bits wide.
package burst_pkg;
    localparam int LANE_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/burst_step_ctr.sv
// Module: burst_step_ctr
// Counts beats taken since the last restart. Restart wins over advance.
// The counter wraps, so beat 0 comes back after 2**STEP_W advances.
// Assumes synchronous active-low reset.
module burst_step_ctr #(
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_i,
    input  logic              advance_i,
    output logic [STEP_W-1:0] step_o
);
    localparam logic [STEP_W-1:0] STEP_ONE  = STEP_W'(1);
    localparam logic [STEP_W-1:0] STEP_LAST = {STEP_W{1'b1}};

    logic [STEP_W-1:0] step_q;

    // Beat counter: clear on reset or restart, bump on advance, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (restart_i) begin
            step_q <= '0;
        end else if (advance_i) begin
            step_q <= step_q + STEP_ONE;
        end
    end

    assign step_o = step_q;

    // R8: a restart always clears the beat count, even when an advance is requested.
    p_restart_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (step_o == '0));

    // R5: the last beat rolls over to beat zero.
    p_step_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && advance_i && step_o == STEP_LAST) |=> (step_o == '0));

    // R6: no restart and no advance means the count holds.
    p_step_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !advance_i) |=> $stable(step_o));
endmodule

// File: rtl/burst_origin_reg.sv
// Module: burst_origin_reg
// Holds the address captured at the start of a burst. The result is split
// into the fixed upper part and the two-bit start offset.
// Assumes synchronous active-low reset and ADDR_W greater than LANE_W.
module burst_origin_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     capture_i,
    input  logic [ADDR_W-1:0]        addr_i,
    output logic [ADDR_W-LANE_W-1:0] upper_o,
    output logic [LANE_W-1:0]        start_o
);
    localparam int UP_W = ADDR_W - LANE_W;

    logic [UP_W-1:0]   upper_q;
    logic [LANE_W-1:0] start_q;

    // Origin capture: load both fields on capture, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q <= '0;
            start_q <= '0;
        end else if (capture_i) begin
            upper_q <= addr_i[ADDR_W-1:LANE_W];
            start_q <= addr_i[LANE_W-1:0];
        end
    end

    assign upper_o = upper_q;
    assign start_o = start_q;

    // R7: the upper part moves only when a capture occurs.
    p_upper_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(upper_o));
endmodule

// File: rtl/burst_lane_map.sv
// Module: burst_lane_map
// Combinational mapping from (start offset, beat count) to the low address
// bits. The order select chooses a modulo-4 sum or a bitwise XOR.
// Assumes both inputs are LANE_W bits wide.
module burst_lane_map
    import burst_pkg::*;
(
    input  logic [LANE_W-1:0] start_i,
    input  logic [LANE_W-1:0] step_i,
    input  order_e            order_i,
    output logic [LANE_W-1:0] lane_o
);
    logic [LANE_W-1:0] lin_lane;
    logic [LANE_W-1:0] ilv_lane;

    // Linear order: wrap-around sum of start and beat count.
    assign lin_lane = start_i + step_i;

    // Interleaved order: each bit flips independently under the beat count.
    for (genvar b = 0; b < LANE_W; b++) begin : g_ilv_bit
        assign ilv_lane[b] = start_i[b] ^ step_i[b];
    end

    // Output select: pick the lane according to the current order.
    always_comb begin
        lane_o = (order_i == ORD_INTERLEAVE) ? ilv_lane : lin_lane;
    end

    // R2: beat zero is the start offset in either order.
    always_comb begin
        if (step_i == '0) begin
            p_first_is_start_r2: assert (lane_o == start_i);
        end
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Module: burst_addr_gen (top)
// Four-beat burst address sequencer. A load captures the start address.
// The active-low advance input steps the beat, and the mode input picks
// linear (0) or interleaved (1) order for the two low bits.
// Assumes synchronous active-low reset; a load takes priority over an advance.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_n_i,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int UP_W = ADDR_W - LANE_W;

    logic [UP_W-1:0]   upper_w;
    logic [LANE_W-1:0] start_w;
    logic [LANE_W-1:0] step_w;
    logic [LANE_W-1:0] lane_w;
    logic              advance_w;
    order_e            order_w;

    // Input qualification: active-high advance and typed order.
    assign advance_w = ~adv_n_i;
    assign order_w   = order_e'(mode_i);

    burst_origin_reg #(
        .ADDR_W (ADDR_W)
    ) u_origin (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (load_i),
        .addr_i    (addr_i),
        .upper_o   (upper_w),
        .start_o   (start_w)
    );

    burst_step_ctr #(
        .STEP_W (LANE_W)
    ) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (load_i),
        .advance_i (advance_w),
        .step_o    (step_w)
    );

    burst_lane_map u_map (
        .start_i (start_w),
        .step_i  (step_w),
        .order_i (order_w),
        .lane_o  (lane_w)
    );

    // Address assembly: fixed upper part above the generated lane.
    assign addr_o = {upper_w, lane_w};

    // R2: a load shows the captured address one cycle later.
    p_load_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o == $past(addr_i)));

    // R6: a suspended cycle keeps the address while the order is unchanged.
    p_suspend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) |=> (!$stable(mode_i) || $stable(addr_o)));

    // R3: a linear advance raises the low bits by one.
    p_linear_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i && !mode_i) |=>
            (mode_i || addr_o[1:0] == $past(addr_o[1:0]) + 2'd1));

    // R4: an interleaved advance changes the low bits by XOR with 01 or 11.
    p_ilv_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i && mode_i) |=>
            (!mode_i || (addr_o[0] != $past(addr_o[0]))));
endmodule

// File: tb/sim_burst_addr_gen.sv
// Bench for burst_addr_gen. A behavioural model, using integers, is updated
// at every rising edge. addr_o is compared with it at every falling edge.
module sim_burst_addr_gen;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic          adv_n_i = 1'b1;
    logic          mode_i = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;

    int     n_checks = 0;
    int     n_fails  = 0;
    bit     done     = 0;
    integer m_upper  = 0;
    integer m_start  = 0;
    integer m_beats  = 0;

    burst_addr_gen #(.ADDR_W(AW)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .adv_n_i (adv_n_i),
        .mode_i  (mode_i),
        .addr_i  (addr_i),
        .addr_o  (addr_o)
    );

    always #5 clk = ~clk;

    function automatic logic [AW-1:0] model_addr();
        integer low;
        if (mode_i) low = m_start ^ m_beats;
        else        low = (m_start + m_beats) % 4;
        return AW'(m_upper * 4 + low);
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: addr_o=%h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle, update the model at the edge, compare at the falling edge.
    task automatic cyc(input bit ld, input bit advn, input bit md, input logic [AW-1:0] a, input string tag);
        load_i = ld; adv_n_i = advn; mode_i = md; addr_i = a;
        @(posedge clk);
        if (!rst_n) begin
            m_upper = 0; m_start = 0; m_beats = 0;
        end else if (ld) begin
            m_upper = int'(a >> 2); m_start = int'(a & 3); m_beats = 0;
        end else if (!advn) begin
            m_beats = (m_beats + 1) % 4;
        end
        @(negedge clk);
        check(tag, addr_o, model_addr());
        n_checks++;
        if (addr_o[AW-1:2] !== AW'(m_upper) >> 0 && addr_o[AW-1:2] !== m_upper[AW-3:0]) begin
            n_fails++;
            $display("FAIL R7: upper=%h expected %h", addr_o[AW-1:2], m_upper[AW-3:0]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        cyc(0, 1, 1, '0, "R1 reset");
        cyc(0, 0, 1, '0, "R1 reset ignores advance");
        rst_n = 1'b1;
        check("R1 reset value", addr_o, '0);
        // R10: advance from reset state, interleaved default order
        cyc(0, 0, 1, '0, "R10 first beat");
        cyc(0, 0, 1, '0, "R10 second beat");
        // R2 + R3 + R5: linear burst from offset 01, full wrap
        cyc(1, 1, 0, 20'hABCD1, "R2 load linear");
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, '0, "R3 R5 linear beat");
        // R6: suspend for two cycles, then resume
        cyc(0, 0, 0, '0, "R3 linear beat");
        cyc(0, 1, 0, 20'h12345, "R6 suspend");
        cyc(0, 1, 0, 20'h54321, "R6 suspend");
        cyc(0, 0, 0, '0, "R3 resume");
        // R4 + R5: interleaved burst from offset 10
        cyc(1, 1, 1, 20'h3C5A2, "R2 load interleaved");
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, '0, "R4 R5 interleaved beat");
        // R9: order change mid-burst, under suspend and then under advance
        cyc(1, 1, 1, 20'h00007, "R2 load offset 11");
        cyc(0, 0, 1, '0, "R4 beat");
        cyc(0, 1, 0, '0, "R9 switch to linear");
        cyc(0, 0, 0, '0, "R9 linear continues");
        cyc(0, 1, 1, '0, "R9 switch to interleaved");
        // R8: load together with advance in the middle of a burst
        cyc(0, 0, 1, '0, "R4 beat");
        cyc(1, 0, 1, 20'hFFFFD, "R8 load with advance");
        cyc(0, 0, 1, '0, "R8 burst restarted");
        // R2: back-to-back loads
        cyc(1, 0, 0, 20'h80002, "R2 back-to-back load a");
        cyc(1, 1, 0, 20'h7FFF1, "R2 back-to-back load b");
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, '0, "R3 R5 linear after reload");
        finish_run();
    end
endmodule